// File: doc/BRIEF.md
# Hi/Lo Multiply Unit

This block is the integer multiplier of a small pipelined processor. It multiplies two 32-bit operands, signed or unsigned, and is built in one of two styles chosen by a parameter. In the held-result style, a multiply instruction leaves its 64-bit product in a pair of architected registers, Hi for the upper word and Lo for the lower word. Two move instructions later copy one of them out to the register file. In the direct style there are no such registers. Each instruction names the half of the product it wants, and that half comes back as an ordinary result.

The multiply takes several clock cycles. The held-result style lets the processor keep issuing other work while the product is being formed. It stalls only when it asks for Hi or Lo before the product is there. The unit reports that stall on `busy`. In the direct style, `busy` covers the whole multiply, and the processor waits for `valid`.

Top module: `mulUnit`

## Requirements
- R1: After reset, `result` is 0, `valid` is 0 and `busy` is 0. In held-result style, both Hi and Lo read back as 0.
- R2: `op` is a 3-bit code: 0 signed multiply into Hi/Lo, 1 unsigned multiply into Hi/Lo, 2 read Hi, 3 read Lo, 4 low half of the product, 5 high half of the signed product, 6 high half of the unsigned product, 7 no operation. A signed operand is two's complement. The product is the full 64-bit value.
- R3: In held-result style, an accepted code 0 or 1 writes the upper product word to Hi and the lower word to Lo. Both are written on the same clock edge, LAT edges after the edge that accepted the multiply. The multiply itself produces no `valid` pulse.
- R4: In held-result style, a read (code 2 or 3) accepted while no multiply is in flight returns the register with `valid` high in the cycle after the accepting edge.
- R5: In held-result style, a read accepted while a multiply is in flight raises `busy` from the next cycle until the multiply completes. The read then returns the new product half with `valid` high in the cycle after the completion edge, and `busy` low. A read accepted on the completion edge itself returns the new half one cycle later without raising `busy`.
- R6: In held-result style, `busy` stays low during a multiply with no read waiting. Any start while `busy` is high is ignored, including a multiply start.
- R7: In held-result style, a multiply started while another is in flight restarts the timing with the new operands. Hi and Lo end up holding the product of the last multiply started.
- R8: In direct style, an accepted code 4, 5 or 6 raises `busy` for LAT cycles starting the cycle after acceptance. The selected half then appears with `valid` high for exactly one cycle, in the same cycle `busy` falls.
- R9: In direct style, a start while `busy` is high is ignored and leaves no later result.
- R10: Codes that belong to the other style, and code 7, are ignored. They give no `valid` and no `busy`, and leave Hi and Lo unchanged.
- R11: `result` keeps its value in every cycle where `valid` is low.
- R12: `busy` and `valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue the operation on `op` this cycle |
| op | input | 3 | Operation code (see R2) |
| opA | input | DATA_W | First multiplicand |
| opB | input | DATA_W | Second multiplicand |
| result | output | DATA_W | Returned word, meaningful while `valid` is high |
| valid | output | 1 | `result` carries a new value this cycle |
| busy | output | 1 | The unit cannot take a start this cycle |

## Verification
The hardest situations to reach are the ones where a read of Hi or Lo meets a multiply on one exact edge. One case is a read landing on the very edge the product completes. Another is a read waiting behind a multiply that was restarted by a second multiply one cycle later. The stimulus drives each start on a falling edge, counted from the multiply's own start, so every such read falls on a chosen rising edge. The expected word is the half of a 64-bit product that the bench computes itself, with signed or unsigned operands. The main sweep pairs every member of a 32-value operand set with every other. The set holds small integers, scattered hashed values, all-ones and both extreme signed values. Each pair is run through every opcode of both styles.

// File: rtl/mulu_pkg.sv
package mulu_pkg;

  // operation codes seen on the op port
  typedef enum logic [2:0] {
    OP_MULT  = 3'd0,
    OP_MULTU = 3'd1,
    OP_RDHI  = 3'd2,
    OP_RDLO  = 3'd3,
    OP_MLO   = 3'd4,
    OP_MHI   = 3'd5,
    OP_MHIU  = 3'd6,
    OP_NONE  = 3'd7
  } mulOp_e;

  // source of the word loaded into the result register
  typedef enum logic [1:0] {
    SEL_HIREG  = 2'd0,
    SEL_LOREG  = 2'd1,
    SEL_PRODHI = 2'd2,
    SEL_PRODLO = 2'd3
  } emitSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadOps;    // capture operands and signedness
    logic     signedOps;  // operands are two's complement
    logic     writeHiLo;  // store the product into Hi and Lo
    logic     emit;       // load the result register
    emitSel_e emitSel;
  } mulStrobe_t;

endpackage

// File: rtl/mulCtrl.sv
module mulCtrl
  import mulu_pkg::*;
#(
  parameter int LAT       = 3,
  parameter int HILO_MODE = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] op,
  output mulStrobe_t strb,
  output logic       validQ,
  output logic       busy
);

  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

  mulOp_e opE;
  assign opE = mulOp_e'(op);

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic             finishing;
  logic             acceptMul;

  // the product is ready on this edge
  assign finishing = running && (cnt == '0);

  if (HILO_MODE != 0) begin : g_hilo
    logic pendQ, pendHiQ, acceptRead, rdHi, pendSet;

    always_comb begin
      rdHi       = (opE == OP_RDHI);
      acceptRead = start && (opE == OP_RDHI || opE == OP_RDLO) && !pendQ;
      acceptMul  = start && (opE == OP_MULT || opE == OP_MULTU) && !pendQ;
      pendSet    = acceptRead && running && !finishing;
      strb           = '0;
      strb.loadOps   = acceptMul;
      strb.signedOps = (opE == OP_MULT);
      strb.writeHiLo = finishing;
      strb.emitSel   = SEL_LOREG;
      if (pendQ && finishing) begin
        strb.emit    = 1'b1;
        strb.emitSel = pendHiQ ? SEL_PRODHI : SEL_PRODLO;
      end else if (acceptRead && !pendSet) begin
        // on the completion edge take the fresh product, else the register
        strb.emit = 1'b1;
        if (finishing) strb.emitSel = rdHi ? SEL_PRODHI : SEL_PRODLO;
        else           strb.emitSel = rdHi ? SEL_HIREG  : SEL_LOREG;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ   <= 1'b0;
        pendHiQ <= 1'b0;
      end else if (pendSet) begin
        pendQ   <= 1'b1;
        pendHiQ <= rdHi;
      end else if (finishing) begin
        pendQ   <= 1'b0;
      end
    end

    assign busy = pendQ;
  end else begin : g_tri
    logic triHiQ;

    always_comb begin
      acceptMul = start && (opE == OP_MLO || opE == OP_MHI || opE == OP_MHIU)
                  && !running;
      strb           = '0;
      strb.loadOps   = acceptMul;
      strb.signedOps = (opE == OP_MHI);
      strb.emitSel   = SEL_PRODLO;
      if (finishing) begin
        strb.emit    = 1'b1;
        strb.emitSel = triHiQ ? SEL_PRODHI : SEL_PRODLO;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          triHiQ <= 1'b0;
      else if (acceptMul) triHiQ <= (opE != OP_MLO);
    end

    assign busy = running;
  end

  // latency counter shared by both styles; a new start restarts it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      validQ  <= 1'b0;
    end else begin
      validQ <= strb.emit;
      if (acceptMul) begin
        running <= 1'b1;
        cnt     <= CNT_W'(LAT - 1);
      end else if (finishing) begin
        running <= 1'b0;
      end else if (running) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/mulPath.sv
module mulPath
  import mulu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int HILO_MODE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulStrobe_t        strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] aQ, bQ;
  logic              sgnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ   <= '0;
      bQ   <= '0;
      sgnQ <= 1'b0;
    end else if (strb.loadOps) begin
      aQ   <= opA;
      bQ   <= opB;
      sgnQ <= strb.signedOps;
    end
  end

  // the extension bit is the sign bit for signed operands and zero otherwise.
  // Replicating it to double width gives the low 2*DATA_W bits of the
  // (DATA_W+1)-bit product.
  logic              aExt, bExt;
  logic [PROD_W-1:0] aWide, bWide, prod;

  assign aExt  = sgnQ & aQ[DATA_W-1];
  assign bExt  = sgnQ & bQ[DATA_W-1];
  assign aWide = {{DATA_W{aExt}}, aQ};
  assign bWide = {{DATA_W{bExt}}, bQ};
  assign prod  = aWide * bWide;

  logic [DATA_W-1:0] hiQ, loQ;

  if (HILO_MODE != 0) begin : g_hilo
    logic [DATA_W-1:0] hiR, loR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiR <= '0;
        loR <= '0;
      end else if (strb.writeHiLo) begin
        hiR <= prod[PROD_W-1:DATA_W];
        loR <= prod[DATA_W-1:0];
      end
    end
    assign hiQ = hiR;
    assign loQ = loR;
  end else begin : g_tri
    assign hiQ = '0;
    assign loQ = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
    end else if (strb.emit) begin
      case (strb.emitSel)
        SEL_HIREG:  result <= hiQ;
        SEL_LOREG:  result <= loQ;
        SEL_PRODHI: result <= prod[PROD_W-1:DATA_W];
        default:    result <= prod[DATA_W-1:0];
      endcase
    end
  end

endmodule

// File: rtl/mulUnit.sv
module mulUnit
  import mulu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LAT       = 3,
  parameter int HILO_MODE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              valid,
  output logic              busy
);

  mulStrobe_t strb;

  mulCtrl #(.LAT(LAT), .HILO_MODE(HILO_MODE)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .op     (op),
    .strb   (strb),
    .validQ (valid),
    .busy   (busy)
  );

  mulPath #(.DATA_W(DATA_W), .HILO_MODE(HILO_MODE)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: rtl/mulUnitChk.sv
module mulUnitChk #(
  parameter int DATA_W    = 32,
  parameter int HILO_MODE = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [2:0]        op,
  input logic [DATA_W-1:0] result,
  input logic              valid,
  input logic              busy
);

  // R12
  busy_valid_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && valid));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> $stable(result));

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> valid);

  // R10
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && op == 3'd7 && !busy) |=> (!valid && !busy));

  // R8
  tri_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (HILO_MODE == 0 && valid) |=> !valid);

  // R8
  tri_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (HILO_MODE == 0 && start && !busy && op >= 3'd4 && op <= 3'd6) |=> busy);

  // R6
  hilo_mul_nobusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (HILO_MODE != 0 && start && !busy && op <= 3'd1) |=> !busy);

endmodule

bind mulUnit mulUnitChk #(.DATA_W(DATA_W), .HILO_MODE(HILO_MODE)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .op     (op),
  .result (result),
  .valid  (valid),
  .busy   (busy)
);

// File: tb/tb_mulUnit.sv
`timescale 1ns/1ps
module tb_mulUnit;
  import mulu_pkg::*;

  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        hStart = 1'b0, tStart = 1'b0;
  logic [2:0]  hOp = 3'd7, tOp = 3'd7;
  logic [31:0] hA = '0, hB = '0, tA = '0, tB = '0;
  logic [31:0] hRes, tRes;
  logic        hVal, hBusy, tVal, tBusy;

  mulUnit #(.DATA_W(32), .LAT(LAT), .HILO_MODE(1)) dut (
    .clk(clk), .rstN(rstN), .start(hStart), .op(hOp), .opA(hA), .opB(hB),
    .result(hRes), .valid(hVal), .busy(hBusy));

  mulUnit #(.DATA_W(32), .LAT(LAT), .HILO_MODE(0)) dutTri (
    .clk(clk), .rstN(rstN), .start(tStart), .op(tOp), .opA(tA), .opB(tB),
    .result(tRes), .valid(tVal), .busy(tBusy));

  int nChk = 0;
  int nBad = 0;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  function automatic logic [31:0] opVal(input int i);
    if (i < 16)  return 32'(i);
    if (i == 29) return 32'hFFFF_FFFF;
    if (i == 30) return 32'h7FFF_FFFF;
    if (i == 31) return 32'h8000_0000;
    return 32'(i) * 32'h9E37_79B1;
  endfunction

  function automatic logic [63:0] refProd(input logic [31:0] a, input logic [31:0] b,
                                          input bit sgn);
    longint sa, sb;
    if (sgn) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    return {32'd0, a} * {32'd0, b};
  endfunction

  // drive at a falling edge, accepted on the next rising edge, return at the falling edge after
  task automatic hDrive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    hStart = 1'b1; hOp = op; hA = a; hB = b;
    @(negedge clk);
    hStart = 1'b0; hOp = OP_NONE;
  endtask

  task automatic tDrive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    tStart = 1'b1; tOp = op; tA = a; tB = b;
    @(negedge clk);
    tStart = 1'b0; tOp = OP_NONE;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    logic [31:0] a, b, c, d, e;
    logic [63:0] p, q;
    logic [2:0]  opSel;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!hVal && !hBusy && hRes == 0, "R1", {hRes, 30'd0, hVal, hBusy}, 0);
    check(!tVal && !tBusy && tRes == 0, "R1", {tRes, 30'd0, tVal, tBusy}, 0);
    hDrive(OP_RDHI, 0, 0);
    check(hVal && hRes == 0, "R1", 64'(hRes), 0);
    hDrive(OP_RDLO, 0, 0);
    check(hVal && hRes == 0, "R1", 64'(hRes), 0);

    // R2 R3 R4 R5 R6 sweep in held-result style
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 32; i++) begin
        for (int j = 0; j < 32; j++) begin
          a = opVal(i); b = opVal(j);
          p = refProd(a, b, s == 0);
          hDrive((s == 0) ? OP_MULT : OP_MULTU, a, b);
          check(!hVal && !hBusy, "R6", 64'({hVal, hBusy}), 0);
          hDrive(OP_RDHI, 0, 0);
          for (int k = 2; k <= LAT; k++) begin
            check(hBusy && !hVal, "R5", 64'({hBusy, hVal}), 64'b10);
            @(negedge clk);
          end
          check(hVal && !hBusy && hRes == p[63:32], "R2 R3", 64'(hRes), 64'(p[63:32]));
          hDrive(OP_RDLO, 0, 0);
          check(hVal && hRes == p[31:0], "R4", 64'(hRes), 64'(p[31:0]));
        end
      end
    end

    // R5 read landing on the completion edge
    a = 32'hDEAD_BEEF; b = 32'h1234_5677;
    p = refProd(a, b, 1'b1);
    hDrive(OP_MULT, a, b);
    repeat (LAT - 1) @(negedge clk);
    hDrive(OP_RDLO, 0, 0);
    check(hVal && !hBusy && hRes == p[31:0], "R5", 64'(hRes), 64'(p[31:0]));
    hDrive(OP_RDHI, 0, 0);
    check(hVal && hRes == p[63:32], "R3", 64'(hRes), 64'(p[63:32]));

    // R7 restart by a second multiply one cycle later
    a = 32'hFFFF_FFF0; b = 32'h0000_0003;
    c = 32'h8000_0001; d = 32'hFFFF_FFFF;
    q = refProd(c, d, 1'b0);
    hDrive(OP_MULT, a, b);
    hDrive(OP_MULTU, c, d);
    hDrive(OP_RDHI, 0, 0);
    repeat (LAT - 1) @(negedge clk);
    check(hVal && hRes == q[63:32], "R7", 64'(hRes), 64'(q[63:32]));
    hDrive(OP_RDLO, 0, 0);
    check(hVal && hRes == q[31:0], "R7", 64'(hRes), 64'(q[31:0]));

    // R6 multiply start while a read waits is ignored
    a = 32'h0000_7FFF; b = 32'hFFFF_8000;
    p = refProd(a, b, 1'b1);
    hDrive(OP_MULT, a, b);
    hDrive(OP_RDHI, 0, 0);
    check(hBusy, "R5", 64'(hBusy), 1);
    hDrive(OP_MULTU, c, d);
    repeat (LAT - 2) @(negedge clk);
    check(hVal && hRes == p[63:32], "R6", 64'(hRes), 64'(p[63:32]));
    repeat (LAT + 1) @(negedge clk);
    hDrive(OP_RDLO, 0, 0);
    check(hVal && hRes == p[31:0], "R6", 64'(hRes), 64'(p[31:0]));

    // R10 foreign and empty codes in held-result style
    hDrive(OP_MHI, c, d);
    hDrive(OP_NONE, c, d);
    hDrive(OP_MLO, c, d);
    for (int k = 0; k <= LAT; k++) begin
      check(!hVal && !hBusy, "R10", 64'({hVal, hBusy}), 0);
      @(negedge clk);
    end
    hDrive(OP_RDLO, 0, 0);
    check(hVal && hRes == p[31:0], "R10", 64'(hRes), 64'(p[31:0]));
    hDrive(OP_RDHI, 0, 0);
    check(hVal && hRes == p[63:32], "R10", 64'(hRes), 64'(p[63:32]));

    // R2 R8 R12 sweep in direct style
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 32; j++) begin
        for (int o = 0; o < 3; o++) begin
          a = opVal(i); b = opVal(j);
          opSel = (o == 0) ? OP_MLO : ((o == 1) ? OP_MHI : OP_MHIU);
          p = refProd(a, b, o != 2);
          e = (o == 0) ? p[31:0] : p[63:32];
          tDrive(opSel, a, b);
          for (int k = 1; k <= LAT; k++) begin
            check(tBusy && !tVal, "R8", 64'({tBusy, tVal}), 64'b10);
            @(negedge clk);
          end
          check(!(tBusy && tVal), "R12", 64'({tBusy, tVal}), 64'b01);
          check(tVal && tRes == e, "R2 R8", 64'(tRes), 64'(e));
        end
      end
    end

    // R9 start while busy is ignored in direct style
    tDrive(OP_MHI, 32'h8000_0000, 32'h8000_0000);
    tDrive(OP_MLO, 32'h0000_0005, 32'h0000_0007);
    repeat (LAT - 1) @(negedge clk);
    check(tVal && tRes == 32'h4000_0000, "R9", 64'(tRes), 64'h4000_0000);
    for (int k = 0; k <= LAT; k++) begin
      @(negedge clk);
      check(!tVal && !tBusy, "R9", 64'({tVal, tBusy}), 0);
    end
    check(tRes == 32'h4000_0000, "R11", 64'(tRes), 64'h4000_0000);

    // R10 foreign and empty codes in direct style
    tDrive(OP_RDHI, 32'h3, 32'h3);
    tDrive(OP_MULT, 32'h3, 32'h3);
    tDrive(OP_NONE, 32'h3, 32'h3);
    for (int k = 0; k <= LAT; k++) begin
      check(!tVal && !tBusy, "R10", 64'({tVal, tBusy}), 0);
      @(negedge clk);
    end
    check(tRes == 32'h4000_0000, "R11", 64'(tRes), 64'h4000_0000);

    report();
  end

endmodule